// File: doc/BRIEF.md
# Single-Bit Boolean Execute Unit

This execute stage handles a family of one-bit logic instructions in a 32-bit controller core. Each cycle it takes a 32-bit instruction word, the destination register value, the source operand value and a random bit. From these it produces a registered write strobe and write value for the destination register. It also updates the carry and zero flags, which it holds itself. The bit position inside the destination comes from the low five bits of the source operand.

A register bit can be moved, ANDed, ORed or XORed with either flag, and either polarity of the flag can be used. The same four operations can also go the other way, with a flag as the target and the register bit, true or inverted, as the source. A bit can be cleared, set, inverted or replaced by a random value, and its prior value can optionally be copied into carry. A dedicated form combines the two flags with each other and does not touch any register.

Fetch, register-file reads, condition-code evaluation and random-number generation all happen outside the unit. A single condition-pass input tells the unit whether the current instruction takes effect.

Top module: `bitlogic_exec`

## Requirements
- R1: While `rst_ni` is low, the carry and zero flags read 0 and `d_we_o` reads 0.
- R2: The instruction word holds, from bit 31 down: condition [31:28], opcode [27:21], C field [20], Z field [19], I [18], D field [17:9] and S field [8:0]. When I=1 the source is the zero-extended S field; otherwise it is `s_val_i`. Only source bits [4:0] pick the bit position n.
- R3: Opcode 0111000 writes the selected flag into bit n of D. The {C,Z} field selects the flag: 00 carry, 01 inverted carry, 10 zero, 11 inverted zero. Every other bit of D is kept.
- R4: Opcodes 0111010, 0111100 and 0111110 replace bit n of D with that bit ANDed, ORed or XORed (respectively) with the flag selected as in R3. Every other bit of D is kept.
- R5: Opcodes 0111001, 0111011, 0111101 and 0111111 apply move, AND, OR or XOR (respectively) from bit n of D into one flag. The C field picks the target flag (0 carry, 1 zero), and the Z field inverts the bit before use. D is not written.
- R6: Opcode 0110110 clears bit n when the Z field is 0 and sets it when the Z field is 1. Opcode 0110111 inverts bit n when the Z field is 0 and loads `rnd_bit_i` into it when the Z field is 1.
- R7: On opcodes 0110110 and 0110111, a C field of 1 loads carry with the value bit n held before the operation. Zero is left unchanged.
- R8: Opcode 0101111 operates on the flags only and uses D-field bits. Bits [1:0] select the operation: 00 move, 01 AND, 10 OR, 11 XOR. Bit [2] selects the target: 0 makes carry the target with zero as the source, and 1 makes zero the target with carry as the source. Bit [3] inverts the source. D is not written.
- R9: When `cond_pass_i` is low, `d_we_o` is 0, `d_wdata_o` equals `d_val_i`, and both flags keep their values.
- R10: Results appear at the outputs one clock edge after the inputs are presented.
- R11: Any other opcode writes neither D nor any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| d_val_i | input | 32 | Current destination register value |
| s_val_i | input | 32 | Source register value (used when I=0) |
| cond_pass_i | input | 1 | Instruction condition satisfied |
| rnd_bit_i | input | 1 | Random bit for the randomize operation |
| d_we_o | output | 1 | Destination register write enable (registered) |
| d_wdata_o | output | 32 | Destination register write value (registered) |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |

## Verification
The flags are internal state, so the cases that depend on a particular flag value are the hardest to reach from the ports: for example, an AND into a register bit with inverted zero while carry is 1. Before each test instruction, the bench loads carry and then zero with two bit-to-flag moves from a register value it chose. This forces all four flag combinations under every opcode, every {C,Z} field value and all 32 bit positions, with random register contents. The flag-only form is swept across all sixteen D-field codes under each flag state.

// File: rtl/bitx_pkg.sv
package bitx_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 7;

  localparam logic [OPC_W-1:0] OPC_BITCLRSET = 7'b0110110;
  localparam logic [OPC_W-1:0] OPC_BITNOTRND = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_FLAGPAIR  = 7'b0101111;
  localparam logic [3:0]       OPC_BOOL_HI   = 4'b0111;

  typedef enum logic [1:0] {
    BOP_MOV = 2'd0,
    BOP_AND = 2'd1,
    BOP_OR  = 2'd2,
    BOP_XOR = 2'd3
  } bop_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_TO_BIT,
    K_TO_FLAG,
    K_UNARY,
    K_FLAGS
  } kind_e;

  typedef enum logic [1:0] {
    U_CLR = 2'd0,
    U_SET = 2'd1,
    U_NOT = 2'd2,
    U_RND = 2'd3
  } uop_e;

  typedef struct packed {
    kind_e kind;
    bop_e  bop;
    uop_e  uop;
    logic  src_z;   // flag source is Z (to-bit form)
    logic  dst_z;   // flag target is Z
    logic  inv;     // invert source
    logic  wr_c;    // unary: copy old bit to carry
    logic  use_imm;
  } dec_t;

  function automatic logic bop_apply(bop_e op, logic a, logic b);
    case (op)
      BOP_MOV: return b;
      BOP_AND: return a & b;
      BOP_OR:  return a | b;
      default: return a ^ b;
    endcase
  endfunction
endpackage

// File: rtl/bitx_decode.sv
module bitx_decode
  import bitx_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [OPC_W-1:0] opc;
  logic             cf, zf;
  logic [8:0]       dfield;

  assign opc    = instr_i[27:21];
  assign cf     = instr_i[20];
  assign zf     = instr_i[19];
  assign dfield = instr_i[17:9];

  always_comb begin
    dec_o         = '0;
    dec_o.kind    = K_NONE;
    dec_o.bop     = BOP_MOV;
    dec_o.uop     = U_CLR;
    dec_o.use_imm = instr_i[18];
    if (opc[6:3] == OPC_BOOL_HI) begin
      dec_o.bop = bop_e'(opc[2:1]);
      dec_o.inv = zf;
      if (!opc[0]) begin
        dec_o.kind  = K_TO_BIT;
        dec_o.src_z = cf;
      end else begin
        dec_o.kind  = K_TO_FLAG;
        dec_o.dst_z = cf;
      end
    end else if (opc == OPC_BITCLRSET || opc == OPC_BITNOTRND) begin
      dec_o.kind = K_UNARY;
      dec_o.uop  = uop_e'({opc[0], zf});
      dec_o.wr_c = cf;
    end else if (opc == OPC_FLAGPAIR) begin
      dec_o.kind  = K_FLAGS;
      dec_o.bop   = bop_e'(dfield[1:0]);
      dec_o.dst_z = dfield[2];
      dec_o.inv   = dfield[3];
    end
  end
endmodule

// File: rtl/bitx_operand.sv
module bitx_operand #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 9,
  localparam int unsigned IDX_W = $clog2(XLEN)
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic [XLEN-1:0]  s_val_i,
  input  logic [XLEN-1:0]  d_val_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             bit_o
);
  logic [XLEN-1:0] src;
  assign src   = use_imm_i ? XLEN'(imm_i) : s_val_i;
  assign idx_o = src[IDX_W-1:0];
  assign bit_o = d_val_i[idx_o];
endmodule

// File: rtl/bitx_alu.sv
module bitx_alu
  import bitx_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned IDX_W = $clog2(XLEN)
) (
  input  dec_t             dec_i,
  input  logic [XLEN-1:0]  d_val_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  input  logic             c_i,
  input  logic             z_i,
  input  logic             rnd_i,
  output logic             d_we_o,
  output logic [XLEN-1:0]  d_new_o,
  output logic             c_we_o,
  output logic             c_new_o,
  output logic             z_we_o,
  output logic             z_new_o
);
  logic nb;

  always_comb begin
    d_we_o  = 1'b0;
    nb      = bit_i;
    c_we_o  = 1'b0;
    c_new_o = c_i;
    z_we_o  = 1'b0;
    z_new_o = z_i;
    case (dec_i.kind)
      K_TO_BIT: begin
        d_we_o = 1'b1;
        nb     = bop_apply(dec_i.bop, bit_i, (dec_i.src_z ? z_i : c_i) ^ dec_i.inv);
      end
      K_TO_FLAG: begin
        if (dec_i.dst_z) begin
          z_we_o  = 1'b1;
          z_new_o = bop_apply(dec_i.bop, z_i, bit_i ^ dec_i.inv);
        end else begin
          c_we_o  = 1'b1;
          c_new_o = bop_apply(dec_i.bop, c_i, bit_i ^ dec_i.inv);
        end
      end
      K_UNARY: begin
        d_we_o  = 1'b1;
        c_we_o  = dec_i.wr_c;
        c_new_o = bit_i;
        case (dec_i.uop)
          U_CLR:   nb = 1'b0;
          U_SET:   nb = 1'b1;
          U_NOT:   nb = ~bit_i;
          default: nb = rnd_i;
        endcase
      end
      K_FLAGS: begin
        if (dec_i.dst_z) begin
          z_we_o  = 1'b1;
          z_new_o = bop_apply(dec_i.bop, z_i, c_i ^ dec_i.inv);
        end else begin
          c_we_o  = 1'b1;
          c_new_o = bop_apply(dec_i.bop, c_i, z_i ^ dec_i.inv);
        end
      end
      default: ;
    endcase
  end

  // per-bit merge: only the addressed lane takes the new value
  for (genvar g = 0; g < XLEN; g++) begin : g_lane
    assign d_new_o[g] = (d_we_o && idx_i == IDX_W'(g)) ? nb : d_val_i[g];
  end
endmodule

// File: rtl/bitlogic_exec.sv
module bitlogic_exec
  import bitx_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned IDX_W = $clog2(XLEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    d_val_i,
  input  logic [XLEN-1:0]    s_val_i,
  input  logic               cond_pass_i,
  input  logic               rnd_bit_i,
  output logic               d_we_o,
  output logic [XLEN-1:0]    d_wdata_o,
  output logic               c_o,
  output logic               z_o
);
  dec_t             dec;
  logic [IDX_W-1:0] idx;
  logic             cur_bit;
  logic             d_we, c_we, z_we, c_new, z_new;
  logic [XLEN-1:0]  d_new;
  logic             c_q, z_q;

  bitx_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  bitx_operand #(.XLEN(XLEN), .IMM_W(9)) u_opnd (
    .imm_i     (instr_i[8:0]),
    .use_imm_i (dec.use_imm),
    .s_val_i   (s_val_i),
    .d_val_i   (d_val_i),
    .idx_o     (idx),
    .bit_o     (cur_bit)
  );

  bitx_alu #(.XLEN(XLEN)) u_alu (
    .dec_i   (dec),
    .d_val_i (d_val_i),
    .idx_i   (idx),
    .bit_i   (cur_bit),
    .c_i     (c_q),
    .z_i     (z_q),
    .rnd_i   (rnd_bit_i),
    .d_we_o  (d_we),
    .d_new_o (d_new),
    .c_we_o  (c_we),
    .c_new_o (c_new),
    .z_we_o  (z_we),
    .z_new_o (z_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_we_o    <= 1'b0;
      d_wdata_o <= '0;
      c_q       <= 1'b0;
      z_q       <= 1'b0;
    end else begin
      d_we_o    <= cond_pass_i & d_we;
      d_wdata_o <= cond_pass_i ? d_new : d_val_i;
      if (cond_pass_i && c_we) c_q <= c_new;
      if (cond_pass_i && z_we) z_q <= z_new;
    end
  end

  assign c_o = c_q;
  assign z_o = z_q;
endmodule

// File: rtl/bitx_checker.sv
module bitx_checker #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned IDX_W = $clog2(XLEN)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [31:0]     instr_i,
  input logic [XLEN-1:0] d_val_i,
  input logic [XLEN-1:0] s_val_i,
  input logic            cond_pass_i,
  input logic            d_we_o,
  input logic [XLEN-1:0] d_wdata_o,
  input logic            c_o,
  input logic            z_o
);
  logic [6:0]       opc;
  logic [XLEN-1:0]  srcv, set_val;
  logic [IDX_W-1:0] n;
  logic             old_bit, is_unary, is_flagpair, is_known;

  assign opc         = instr_i[27:21];
  assign srcv        = instr_i[18] ? XLEN'(instr_i[8:0]) : s_val_i;
  assign n           = srcv[IDX_W-1:0];
  assign old_bit     = d_val_i[n];
  assign set_val     = d_val_i | (XLEN'(1) << n);
  assign is_unary    = (opc == 7'b0110110) || (opc == 7'b0110111);
  assign is_flagpair = (opc == 7'b0101111);
  assign is_known    = is_unary || is_flagpair || (opc[6:3] == 4'b0111);

  AST_HOLD_ON_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_pass_i |=> !d_we_o && $stable(c_o) && $stable(z_o)); // R9

  AST_ONE_BIT_CHANGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $countones(d_wdata_o ^ $past(d_val_i)) <= 1); // R3

  AST_FLAGPAIR_NO_DWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_pass_i && is_flagpair |=> !d_we_o); // R8

  AST_SETB_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_pass_i && opc == 7'b0110110 && instr_i[19] |=> d_we_o && d_wdata_o == $past(set_val)); // R6

  AST_CARRY_OLD_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_pass_i && is_unary && instr_i[20] |=> c_o == $past(old_bit) && $stable(z_o)); // R7

  AST_UNKNOWN_OP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_pass_i && !is_known |=> !d_we_o && $stable(c_o) && $stable(z_o)); // R11
endmodule

bind bitlogic_exec bitx_checker #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_i     (instr_i),
  .d_val_i     (d_val_i),
  .s_val_i     (s_val_i),
  .cond_pass_i (cond_pass_i),
  .d_we_o      (d_we_o),
  .d_wdata_o   (d_wdata_o),
  .c_o         (c_o),
  .z_o         (z_o)
);

// File: tb/tb_bitlogic_exec.sv
module tb_bitlogic_exec;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] d_val_i = '0;
  logic [31:0] s_val_i = '0;
  logic        cond_pass_i = 1'b0;
  logic        rnd_bit_i = 1'b0;
  logic        d_we_o;
  logic [31:0] d_wdata_o;
  logic        c_o, z_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic mc = 1'b0, mz = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bitlogic_exec dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i), .d_val_i(d_val_i),
    .s_val_i(s_val_i), .cond_pass_i(cond_pass_i), .rnd_bit_i(rnd_bit_i),
    .d_we_o(d_we_o), .d_wdata_o(d_wdata_o), .c_o(c_o), .z_o(z_o)
  );

  function automatic logic [31:0] mk(logic [6:0] opc, logic cf, logic zf, logic im,
                                     logic [8:0] df, logic [8:0] sf);
    return {4'hF, opc, cf, zf, im, df, sf};
  endfunction

  function automatic logic lop(logic [1:0] op, logic a, logic b);
    case (op)
      2'd0: return b;
      2'd1: return a & b;
      2'd2: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic string tag_of(logic [31:0] ins);
    logic [6:0] o = ins[27:21];
    if (o[6:3] == 4'b0111) return o[0] ? "R5" : (o[2:1] == 2'd0 ? "R3" : "R4");
    if (o == 7'h36 || o == 7'h37) return ins[20] ? "R7" : "R6";
    if (o == 7'h2F) return "R8";
    return "R11";
  endfunction

  // reference model written from the requirements
  task automatic model(input logic [31:0] ins, d, s, input logic cp, rnd,
                       output logic we, output logic [31:0] dn, output logic cn, zn);
    logic [6:0]  o;
    logic [31:0] sv;
    logic [4:0]  pos;
    logic        b, r;
    o   = ins[27:21];
    sv  = ins[18] ? {23'd0, ins[8:0]} : s;
    pos = sv[4:0];
    b   = d[pos];
    we = 1'b0; dn = d; cn = mc; zn = mz; r = b;
    if (cp) begin
      if (o[6:3] == 4'b0111 && !o[0]) begin
        r  = lop(o[2:1], b, (ins[20] ? mz : mc) ^ ins[19]);
        we = 1'b1;
      end else if (o[6:3] == 4'b0111) begin
        if (ins[20]) zn = lop(o[2:1], mz, b ^ ins[19]);
        else         cn = lop(o[2:1], mc, b ^ ins[19]);
      end else if (o == 7'h36 || o == 7'h37) begin
        we = 1'b1;
        if (o == 7'h36) r = ins[19];
        else            r = ins[19] ? rnd : ~b;
        if (ins[20]) cn = b;
      end else if (o == 7'h2F) begin
        if (ins[11]) zn = lop(ins[10:9], mz, mc ^ ins[12]);
        else         cn = lop(ins[10:9], mc, mz ^ ins[12]);
      end
      if (we) dn = (d & ~(32'd1 << pos)) | ({31'd0, r} << pos);
    end
  endtask

  // called at a negedge; drives, waits one edge, compares at next negedge
  task automatic step(input logic [31:0] ins, d, s, input logic cp, rnd, input string tg);
    logic we, cn, zn;
    logic [31:0] dn;
    string t;
    instr_i = ins; d_val_i = d; s_val_i = s; cond_pass_i = cp; rnd_bit_i = rnd;
    model(ins, d, s, cp, rnd, we, dn, cn, zn);
    t = (tg == "") ? tag_of(ins) : tg;
    @(negedge clk_i);
    checks++;
    if ({d_we_o, d_wdata_o, c_o, z_o} !== {we, dn, cn, zn}) begin
      fails++;
      $display("FAIL %s ins=%h actual we=%b d=%h c=%b z=%b expected we=%b d=%h c=%b z=%b",
               t, ins, d_we_o, d_wdata_o, c_o, z_o, we, dn, cn, zn);
    end
    mc = cn; mz = zn;
  endtask

  task automatic load_flags(input logic fc, fz);
    step(mk(7'h39, 1'b0, 1'b0, 1'b1, 9'd0, 9'd0), {31'h0, fc}, 32'd0, 1'b1, 1'b0, "R5");
    step(mk(7'h39, 1'b1, 1'b0, 1'b1, 9'd0, 9'd0), {31'h0, fz}, 32'd0, 1'b1, 1'b0, "R5");
  endtask

  task automatic chk(input logic ok, input string tg, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(c_o === 1'b0, "R1", {31'd0, c_o}, 32'd0);
    chk(z_o === 1'b0, "R1", {31'd0, z_o}, 32'd0);
    chk(d_we_o === 1'b0, "R1", {31'd0, d_we_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // near-exhaustive sweep: opcode x {C,Z} x position x flag state
    for (int o = 7'h36; o <= 7'h3F; o++)
      for (int cz = 0; cz < 4; cz++)
        for (int p = 0; p < 32; p++)
          for (int fl = 0; fl < 4; fl++) begin
            load_flags(fl[1], fl[0]);
            step(mk(7'(o), cz[1], cz[0], 1'b1, 9'($urandom), {4'($urandom), 5'(p)}),
                 $urandom, $urandom, 1'b1, 1'($urandom), "");
          end

    // register source path, upper source bits ignored
    for (int k = 0; k < 300; k++)
      step(mk(7'(7'h36 + ($urandom % 10)), 1'($urandom), 1'($urandom), 1'b0, 9'($urandom), 9'($urandom)),
           $urandom, $urandom, 1'b1, 1'($urandom), "R2");

    // flag-only form, all codes under all flag states
    for (int dd = 0; dd < 16; dd++)
      for (int fl = 0; fl < 4; fl++) begin
        load_flags(fl[1], fl[0]);
        step(mk(7'h2F, 1'($urandom), 1'($urandom), 1'($urandom), {5'($urandom), 4'(dd)}, 9'($urandom)),
             $urandom, $urandom, 1'b1, 1'b0, "R8");
      end

    // condition failed: nothing changes
    for (int k = 0; k < 200; k++) begin
      if (k % 8 == 0) load_flags(1'($urandom), 1'($urandom));
      step(mk(7'(7'h2F + ($urandom % 17)), 1'($urandom), 1'($urandom), 1'($urandom), 9'($urandom), 9'($urandom)),
           $urandom, $urandom, 1'b0, 1'($urandom), "R9");
    end

    // unrecognized opcodes
    for (int o = 0; o < 128; o++) begin
      if (o == 7'h2F || o == 7'h36 || o == 7'h37 || o >= 7'h38) continue;
      load_flags(1'($urandom), 1'($urandom));
      step(mk(7'(o), 1'($urandom), 1'($urandom), 1'($urandom), 9'($urandom), 9'($urandom)),
           $urandom, $urandom, 1'b1, 1'($urandom), "R11");
    end

    // latency: output unchanged before the edge, updated after it
    step(mk(7'h36, 1'b0, 1'b1, 1'b1, 9'd0, 9'd7), 32'h0, 32'h0, 1'b0, 1'b0, "R9");
    instr_i = mk(7'h36, 1'b0, 1'b1, 1'b1, 9'd0, 9'd7);
    d_val_i = 32'h0; cond_pass_i = 1'b1;
    #1;
    chk(d_we_o === 1'b0, "R10", {31'd0, d_we_o}, 32'd0);
    @(negedge clk_i);
    chk(d_we_o === 1'b1 && d_wdata_o === 32'h80, "R10", d_wdata_o, 32'h80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule